// File: doc/BRIEF.md
# Low-Power Timekeeping Counter with Two Compares

This block is a free-running up-counter that runs on a slow timekeeping clock, so that time is kept while the rest of the chip sleeps. It counts one step per clock while enabled. By default it wraps from all-ones back to zero. Optionally, compare value 0 can act as the top of the count, so that the period becomes programmable.

Two compare inputs are matched against the count on every cycle. Matches and wraps set bits in a sticky flag register. A clear input removes those bits, and an enable mask gates them onto a single interrupt line. The counter can pause while a debugger holds the core, unless running in debug is allowed. Turning the enable off freezes the count, and turning it back on restarts the count from zero.

Configuration inputs are assumed to be already synchronous to the counter clock.

Top module: `lp_rtc`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0, `flags_o` is 0, `ovf_o` is 0 and `irq_o` is 0.
- R2: While `en_i` stays high and the counter is not paused, `count_o` rises by one at each clock edge.
- R3: With `top_sel_i` low, the count goes from all-ones (2^CW-1) to 0. `ovf_o` is high for exactly the cycle in which `count_o` shows that 0.
- R4: With `top_sel_i` high, the count goes from the value of `cmp0_i` to 0, and `ovf_o` pulses as in R3.
- R5: If the top value is below the current count, the counter keeps counting up to all-ones and wraps only there.
- R6: While `en_i` is low, `count_o` holds its value. At the first edge with `en_i` high again, `count_o` becomes 0, and counting continues from there.
- R7: With `dbg_halt_i` high and `dbg_run_i` low, the count holds. With `dbg_run_i` high, the count ignores `dbg_halt_i`.
- R8: `match_o[i]` is high while `en_i` is high and `count_o` equals `cmp<i>_i`. The flag bits are: bit 0 for compare 0, bit 1 for compare 1, and bit 2 for wrap. Each bit sets at the edge after its event and stays set until it is cleared.
- R9: A high bit in `flag_clr_i` clears the same bit of `flags_o` at the next edge. If a set event for that bit happens in the same cycle, the set wins.
- R10: `irq_o` is the OR over all bits of `flags_o` AND `irq_en_i`, and it follows `irq_en_i` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency counter clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| en_i | input | 1 | Count enable; a rising level restarts from zero |
| dbg_run_i | input | 1 | Keep counting while the debugger halts the core |
| dbg_halt_i | input | 1 | Core is halted by a debugger |
| top_sel_i | input | 1 | Use compare 0 as the wrap value |
| cmp0_i | input | CW | Compare value 0 |
| cmp1_i | input | CW | Compare value 1 |
| irq_en_i | input | 3 | Interrupt enable per flag bit |
| flag_clr_i | input | 3 | Clear strobe per flag bit |
| count_o | output | CW | Current count |
| match_o | output | 2 | Live compare equality, one bit per compare |
| ovf_o | output | 1 | One-cycle wrap indication |
| flags_o | output | 3 | Sticky flags: compare 0, compare 1, wrap |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the counter with CW set to 8, so that the all-ones wrap at 255 happens after a few hundred cycles instead of sixteen million. At that width the bench can walk the whole run-past-top case of R5 with a short compare-0 top and check every step up to the wrap. It also reaches both sticky compare flags and the wrap flag within one pass.

// File: rtl/lp_rtc.sv
module lp_rtc #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          dbg_run_i,
  input  logic          dbg_halt_i,
  input  logic          top_sel_i,
  input  logic [CW-1:0] cmp0_i,
  input  logic [CW-1:0] cmp1_i,
  input  logic [2:0]    irq_en_i,
  input  logic [2:0]    flag_clr_i,
  output logic [CW-1:0] count_o,
  output logic [1:0]    match_o,
  output logic          ovf_o,
  output logic [2:0]    flags_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;
  logic          en_q;
  logic          ovf_q;
  logic [2:0]    flags;

  wire          run     = en_i && (dbg_run_i || !dbg_halt_i);
  wire          restart = en_i && !en_q;
  wire [CW-1:0] top     = top_sel_i ? cmp0_i : CMAX;
  wire          at_end  = (cnt == top) || (cnt == CMAX);
  wire          wrap    = run && !restart && at_end;

  assign match_o = {en_i && (cnt == cmp1_i), en_i && (cnt == cmp0_i)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      flags <= '0;
    end else begin
      en_q  <= en_i;
      ovf_q <= wrap;
      flags <= (flags & ~flag_clr_i) | {wrap, match_o};
      if (restart)
        cnt <= '0;
      else if (run)
        cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  assign count_o = cnt;
  assign ovf_o   = ovf_q;
  assign flags_o = flags;
  assign irq_o   = |(flags & irq_en_i);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !at_end) |=> (count_o == $past(count_o) + CW'(1)));

  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> $stable(count_o));

  // R7
  dbg_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && en_q && dbg_halt_i && !dbg_run_i) |=> $stable(count_o));

  // R3
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (count_o == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags_o) & ~$past(flag_clr_i)) & ~flags_o) == 3'b000));
endmodule

// File: tb/lp_rtc_bench.sv
module lp_rtc_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en_i, dbg_run_i, dbg_halt_i, top_sel_i;
  logic [CW-1:0] cmp0_i, cmp1_i;
  logic [2:0]    irq_en_i, flag_clr_i;
  logic [CW-1:0] count_o;
  logic [1:0]    match_o;
  logic          ovf_o;
  logic [2:0]    flags_o;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lp_rtc #(.CW(CW)) u_lp_rtc (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .dbg_run_i(dbg_run_i),
    .dbg_halt_i(dbg_halt_i), .top_sel_i(top_sel_i), .cmp0_i(cmp0_i),
    .cmp1_i(cmp1_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .count_o(count_o), .match_o(match_o), .ovf_o(ovf_o),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  // {en, halt, dbg_run, expected count after the edge}
  localparam logic [10:0] VEC [12] = '{
    {3'b100, 8'd0}, {3'b100, 8'd1}, {3'b100, 8'd2}, {3'b110, 8'd2},
    {3'b110, 8'd2}, {3'b111, 8'd3}, {3'b100, 8'd4}, {3'b000, 8'd4},
    {3'b000, 8'd4}, {3'b100, 8'd0}, {3'b100, 8'd1}, {3'b100, 8'd2}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int prev;
    int early;
    rst_n = 1'b0; en_i = 1'b0; dbg_run_i = 1'b0; dbg_halt_i = 1'b0;
    top_sel_i = 1'b0; cmp0_i = 8'd200; cmp1_i = 8'd201;
    irq_en_i = 3'b111; flag_clr_i = 3'b000;
    tick(); tick();
    chk("R1 count", int'(count_o), 0);
    chk("R1 flags", int'(flags_o), 0);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    irq_en_i = 3'b000;

    // R2 R6 R7 table walk
    for (int i = 0; i < 12; i++) begin
      en_i = VEC[i][10]; dbg_halt_i = VEC[i][9]; dbg_run_i = VEC[i][8];
      tick();
      chk($sformatf("R2/R6/R7 row %0d", i), int'(count_o), int'(VEC[i][7:0]));
    end
    dbg_halt_i = 1'b0; dbg_run_i = 1'b0;

    // R3 R8 wrap at all-ones
    while (count_o != 8'd255) begin
      if (count_o == 8'd200) chk("R8 match0", int'(match_o), 1);
      tick();
    end
    chk("R3 no ovf before wrap", int'(ovf_o), 0);
    chk("R3 no wrap flag before wrap", int'(flags_o[2]), 0);
    tick();
    chk("R3 count wraps to 0", int'(count_o), 0);
    chk("R3 ovf pulse", int'(ovf_o), 1);
    chk("R8 flags set", int'(flags_o), 7);
    tick();
    chk("R3 ovf one cycle", int'(ovf_o), 0);
    chk("R8 flags sticky", int'(flags_o), 7);

    // R10 combinational mask
    irq_en_i = 3'b100; #1;
    chk("R10 irq enabled", int'(irq_o), 1);
    irq_en_i = 3'b000; #1;
    chk("R10 irq masked", int'(irq_o), 0);

    // R9 clear and set priority
    flag_clr_i = 3'b111;
    tick();
    chk("R9 clear all", int'(flags_o), 0);
    cmp1_i = count_o;
    flag_clr_i = 3'b010;
    tick();
    chk("R9 set wins", int'(flags_o[1]), 1);
    cmp1_i = 8'd201;
    tick();
    chk("R9 clear bit1", int'(flags_o[1]), 0);
    flag_clr_i = 3'b000;
    irq_en_i = 3'b010; #1;
    chk("R10 irq idle", int'(irq_o), 0);
    irq_en_i = 3'b000;

    // R4 compare-0 top
    top_sel_i = 1'b1; cmp0_i = 8'd10;
    en_i = 1'b0; tick();
    en_i = 1'b1; tick();
    chk("R6 restart zero", int'(count_o), 0);
    repeat (10) tick();
    chk("R4 reach top", int'(count_o), 10);
    tick();
    chk("R4 wrap at top", int'(count_o), 0);
    chk("R4 ovf pulse", int'(ovf_o), 1);

    // R5 top below count
    top_sel_i = 1'b0;
    while (count_o != 8'd20) tick();
    top_sel_i = 1'b1;
    early = 0;
    while (count_o != 8'd255) begin
      prev = int'(count_o);
      tick();
      if (int'(count_o) != prev + 1) early = 1;
    end
    chk("R5 runs past top", early, 0);
    tick();
    chk("R5 wraps at all-ones", int'(count_o), 0);
    chk("R5 ovf pulse", int'(ovf_o), 1);

    summary();
    $finish;
  end
endmodule